// File: doc/BRIEF.md
# Dual Pulse-Density DAC Modulator

This block produces two independent one-bit pulse-density streams. Each stream carries a 9-bit code and is meant to drive an external RC low-pass filter that recovers an analog level. For each channel, a per-channel select input picks the code. The code comes either from a manually written value or from a temperature-indexed lookup value, and both arrive on input ports. A first-order accumulator generates each stream, so the ones are spread evenly through time. Fixed-period PWM bunches them together, and at the same clock rate it leaves far more ripple after the filter.

Both channels share a 512-step frame. A channel takes in a new code only on the first step of a frame, so a code written part-way through a frame never produces a partial, glitched frame. A clock-enable input sets the step rate, which lets the modulator run at a fraction of the system clock. Until the init-done input is asserted, both output-enables stay low, both data outputs stay at zero, and all modulator state is held cleared. The pads are therefore high impedance.

Top module: `dsm_dac_dual`

## Requirements
- R1: After reset, every `dac_oe` bit is 0 and every `dac_bit` bit is 0.
- R2: While `init_done` is 0, `dac_oe` and `dac_bit` stay all-zero one cycle later whatever the other inputs do. Once `init_done` is 1, `dac_oe` is all-ones from the following cycle.
- R3: Over one 512-step frame that starts at the rise of `init_done`, channel n emits exactly as many ones as its code value. Channel n's code occupies bits [9n+8:9n] of the code buses.
- R4: When `use_lut[n]` is 1, channel n uses its slice of `lut_code`. When it is 0, channel n uses its slice of `manual_code`.
- R5: Code 0 gives no ones at all over a frame. Code 511 gives 511 ones in 512 steps.
- R6: A code change made after the first step of a frame has no effect on that frame. The new value takes effect from the next frame.
- R7: A rising clock edge with `mod_en` 0 is not a step: `dac_bit` holds its value. With `mod_en` alternating, 512 enabled steps still give exactly the code's count of ones.
- R8: The two channels run independently, and each has its own count of ones for different codes in the same frame.
- R9: Dropping `init_done` clears the accumulators and the frame position. After re-assertion, the first frame again gives exactly the code's count of ones.
- R10: The ones are spread rather than grouped. With code 256 the stream alternates on every step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_done | input | 1 | High once initialization has finished. While low, it holds the outputs off and clears the state |
| mod_en | input | 1 | Modulator step enable (clock divider input) |
| use_lut | input | 2 | Per-channel source select: 1 selects the lookup code, 0 selects the manual code |
| manual_code | input | 18 | Manual codes, 9 bits per channel, channel 0 in the low bits |
| lut_code | input | 18 | Temperature-indexed codes, 9 bits per channel, channel 0 in the low bits |
| dac_bit | output | 2 | Pulse-density stream per channel, forced to 0 while disabled |
| dac_oe | output | 2 | Output-enable per channel |

## Verification
The hardest case to reach from the ports is a code change that lands part-way through a frame. The frame position is not visible on any port. The stimulus therefore starts each frame at a known point, the rise of `init_done`, counts 100 steps and then rewrites the code. The bench expects the ones in the first full frame to match the old code and the ones in the second frame to match the new one. Divided-rate operation is reached by toggling `mod_en` on every cycle. Ones are counted only on enabled edges, and the output is checked for no change on the disabled ones.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
    localparam int DEF_CODE_W = 9;
    localparam int DEF_NUM_CH = 2;

    typedef enum logic {
        SRC_MANUAL = 1'b0,
        SRC_TABLE  = 1'b1
    } code_src_e;
endpackage

// File: rtl/dsm_frame_timer.sv
module dsm_frame_timer #(
    parameter int CODE_W = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic step_i,
    output logic frame_start_o
);
    localparam logic [CODE_W-1:0] LAST_POS = {CODE_W{1'b1}};

    typedef struct packed {
        logic [CODE_W-1:0] pos;
    } ft_state_t;

    ft_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.pos = '0;
        end else if (step_i) begin
            st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_start_o = (st_q.pos == '0);

    // R3: a frame spans exactly 2**CODE_W steps before it wraps
    p_frame_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && st_q.pos == LAST_POS) |=> (st_q.pos == '0));

    // R9: a clear returns the frame position to its start
    p_frame_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> frame_start_o);
endmodule

// File: rtl/dsm_code_sel.sv
module dsm_code_sel
    import dsm_pkg::*;
#(
    parameter int CODE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              step_i,
    input  logic              frame_start_i,
    input  logic              use_lut_i,
    input  logic [CODE_W-1:0] manual_i,
    input  logic [CODE_W-1:0] lut_i,
    output logic [CODE_W-1:0] code_o
);
    typedef struct packed {
        logic [CODE_W-1:0] active;
    } cs_state_t;

    cs_state_t         st_d, st_q;
    code_src_e         src;
    logic [CODE_W-1:0] picked;

    always_comb begin
        src    = use_lut_i ? SRC_TABLE : SRC_MANUAL;
        picked = (src == SRC_TABLE) ? lut_i : manual_i;
        code_o = frame_start_i ? picked : st_q.active;
        st_d   = st_q;
        if (clr_i) begin
            st_d.active = '0;
        end else if (step_i && frame_start_i) begin
            st_d.active = picked;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: the held code moves only on the first step of a frame
    p_hold_mid_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !(step_i && frame_start_i)) |=> $stable(st_q.active));
endmodule

// File: rtl/dsm_modulator.sv
module dsm_modulator #(
    parameter int CODE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              step_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              bit_o
);
    localparam int SUM_W = CODE_W + 1;

    typedef struct packed {
        logic [CODE_W-1:0] acc;
        logic              pulse;
    } md_state_t;

    md_state_t        st_d, st_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum  = {1'b0, st_q.acc} + {1'b0, code_i};
        st_d = st_q;
        if (clr_i) begin
            st_d.acc   = '0;
            st_d.pulse = 1'b0;
        end else if (step_i) begin
            st_d.acc   = sum[CODE_W-1:0];
            st_d.pulse = sum[CODE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_o = st_q.pulse;

    // R7: a non-step edge leaves the modulator untouched
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clr_i) |=> ($stable(st_q.acc) && $stable(st_q.pulse)));

    // R5: a zero code from an empty accumulator never yields a one
    p_zero_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && code_i == '0 && st_q.acc == '0) |=> (!bit_o && st_q.acc == '0));

    // R9: clearing empties the accumulator and silences the output
    p_mod_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.acc == '0 && !bit_o));
endmodule

// File: rtl/dsm_dac_dual.sv
module dsm_dac_dual
    import dsm_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W,
    parameter int NUM_CH = DEF_NUM_CH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     init_done,
    input  logic                     mod_en,
    input  logic [NUM_CH-1:0]        use_lut,
    input  logic [NUM_CH*CODE_W-1:0] manual_code,
    input  logic [NUM_CH*CODE_W-1:0] lut_code,
    output logic [NUM_CH-1:0]        dac_bit,
    output logic [NUM_CH-1:0]        dac_oe
);
    typedef struct packed {
        logic oe;
    } top_state_t;

    top_state_t        st_d, st_q;
    logic              step;
    logic              clr;
    logic              frame_start;
    logic [NUM_CH-1:0] raw_bit;

    always_comb begin
        clr     = !init_done;
        step    = init_done && mod_en;
        st_d    = st_q;
        st_d.oe = init_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dsm_frame_timer #(.CODE_W(CODE_W)) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr_i         (clr),
        .step_i        (step),
        .frame_start_o (frame_start)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [CODE_W-1:0] code_now;

        dsm_code_sel #(.CODE_W(CODE_W)) u_sel (
            .clk           (clk),
            .rst_n         (rst_n),
            .clr_i         (clr),
            .step_i        (step),
            .frame_start_i (frame_start),
            .use_lut_i     (use_lut[ch]),
            .manual_i      (manual_code[ch*CODE_W +: CODE_W]),
            .lut_i         (lut_code[ch*CODE_W +: CODE_W]),
            .code_o        (code_now)
        );

        dsm_modulator #(.CODE_W(CODE_W)) u_mod (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clr),
            .step_i (step),
            .code_i (code_now),
            .bit_o  (raw_bit[ch])
        );

        assign dac_bit[ch] = raw_bit[ch] & st_q.oe;
        assign dac_oe[ch]  = st_q.oe;
    end

    // R2: outputs are off in the cycle after init_done is low
    p_off_before_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |=> (dac_oe == '0 && dac_bit == '0));

    // R2: the enables come up one cycle after init_done
    p_on_after_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> (dac_oe == {NUM_CH{1'b1}}));
endmodule

// File: tb/tb_dsm_dac_dual.sv
module tb_dsm_dac_dual;
    localparam int CW = 9;
    localparam int NC = 2;
    localparam int FRAME = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          init_done = 1'b0;
    logic          mod_en = 1'b0;
    logic [NC-1:0] use_lut = '0;
    logic [NC*CW-1:0] manual_code = '0;
    logic [NC*CW-1:0] lut_code = '0;
    logic [NC-1:0] dac_bit;
    logic [NC-1:0] dac_oe;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    dsm_dac_dual dut (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .mod_en(mod_en),
        .use_lut(use_lut), .manual_code(manual_code), .lut_code(lut_code),
        .dac_bit(dac_bit), .dac_oe(dac_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_codes(input int m0, input int m1, input int l0, input int l1);
        manual_code = {m1[CW-1:0], m0[CW-1:0]};
        lut_code    = {l1[CW-1:0], l0[CW-1:0]};
    endtask

    task automatic park();
        @(negedge clk);
        init_done = 1'b0;
        mod_en    = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic count_steps(input int n, output int c0, output int c1);
        c0 = 0;
        c1 = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            c0 += int'(dac_bit[0]);
            c1 += int'(dac_bit[1]);
        end
    endtask

    task automatic launch();
        @(negedge clk);
        init_done = 1'b1;
        mod_en    = 1'b1;
    endtask

    task automatic t_reset();
        chk(dac_oe == '0, "R1 oe after reset", int'(dac_oe), 0);
        chk(dac_bit == '0, "R1 bit after reset", int'(dac_bit), 0);
        rst_n = 1'b1;
        set_codes(300, 400, 500, 200);
        mod_en = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(dac_oe == '0 && dac_bit == '0, "R2 off while init low",
                int'({dac_oe, dac_bit}), 0);
        end
    endtask

    task automatic t_manual();
        int c0, c1;
        park();
        use_lut = 2'b00;
        set_codes(100, 377, 7, 9);
        launch();
        @(negedge clk);
        chk(dac_oe == 2'b11, "R2 oe after init", int'(dac_oe), 3);
        count_steps(FRAME - 1, c0, c1);
        c0 += 0;
        c1 += 0;
        chk(c0 == 100 || c0 == 99, "R3 ch0 partial", c0, 100);
        park();
        launch();
        count_steps(FRAME, c0, c1);
        chk(c0 == 100, "R3 ch0 manual ones", c0, 100);
        chk(c1 == 377, "R8 ch1 manual ones", c1, 377);
    endtask

    task automatic t_lut();
        int c0, c1;
        park();
        use_lut = 2'b11;
        set_codes(10, 20, 45, 300);
        launch();
        count_steps(FRAME, c0, c1);
        chk(c0 == 45, "R4 ch0 lut", c0, 45);
        chk(c1 == 300, "R4 ch1 lut", c1, 300);
        park();
        use_lut = 2'b01;
        launch();
        count_steps(FRAME, c0, c1);
        chk(c0 == 45, "R4 ch0 lut mixed", c0, 45);
        chk(c1 == 20, "R4 ch1 manual mixed", c1, 20);
    endtask

    task automatic t_extremes();
        int c0, c1;
        park();
        use_lut = 2'b00;
        set_codes(0, 511, 0, 0);
        launch();
        count_steps(FRAME, c0, c1);
        chk(c0 == 0, "R5 code 0 no ones", c0, 0);
        chk(c1 == 511, "R5 code 511 ones", c1, 511);
    endtask

    task automatic t_midframe();
        int a0, a1, b0, b1;
        park();
        use_lut = 2'b00;
        set_codes(50, 400, 0, 0);
        launch();
        count_steps(100, a0, a1);
        set_codes(250, 5, 0, 0);
        count_steps(FRAME - 100, b0, b1);
        chk(a0 + b0 == 50, "R6 ch0 old code kept", a0 + b0, 50);
        chk(a1 + b1 == 400, "R6 ch1 old code kept", a1 + b1, 400);
        count_steps(FRAME, b0, b1);
        chk(b0 == 250, "R6 ch0 new frame", b0, 250);
        chk(b1 == 5, "R6 ch1 new frame", b1, 5);
    endtask

    task automatic t_divided();
        int c0, c1, bad;
        logic [NC-1:0] prev;
        park();
        use_lut = 2'b00;
        set_codes(123, 333, 0, 0);
        launch();
        c0 = 0;
        c1 = 0;
        bad = 0;
        prev = '0;
        for (int i = 0; i < 2 * FRAME; i++) begin
            @(negedge clk);
            if (mod_en) begin
                c0 += int'(dac_bit[0]);
                c1 += int'(dac_bit[1]);
            end else if (dac_bit != prev) begin
                bad++;
            end
            prev   = dac_bit;
            mod_en = ~mod_en;
        end
        chk(bad == 0, "R7 hold on disabled edge", bad, 0);
        chk(c0 == 123, "R7 ch0 divided ones", c0, 123);
        chk(c1 == 333, "R7 ch1 divided ones", c1, 333);
    endtask

    task automatic t_density();
        int flips;
        logic [NC-1:0] prev;
        park();
        use_lut = 2'b00;
        set_codes(256, 256, 0, 0);
        launch();
        @(negedge clk);
        prev = dac_bit;
        flips = 0;
        for (int i = 1; i < 64; i++) begin
            @(negedge clk);
            if (dac_bit[0] != prev[0]) flips++;
            prev = dac_bit;
        end
        chk(flips == 63, "R10 alternating stream", flips, 63);
    endtask

    task automatic t_restart();
        int c0, c1;
        park();
        use_lut = 2'b00;
        set_codes(200, 77, 0, 0);
        launch();
        count_steps(300, c0, c1);
        @(negedge clk);
        init_done = 1'b0;
        @(negedge clk);
        chk(dac_oe == '0, "R9 oe off on drop", int'(dac_oe), 0);
        set_codes(60, 444, 0, 0);
        launch();
        count_steps(FRAME, c0, c1);
        chk(c0 == 60, "R9 ch0 clean restart", c0, 60);
        chk(c1 == 444, "R9 ch1 clean restart", c1, 444);
    endtask

    bit finished = 1'b0;

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_manual();
        t_lut();
        t_extremes();
        t_midframe();
        t_divided();
        t_density();
        t_restart();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule